// File: doc/BRIEF.md
# Master-Slave PWM Timer Pair

This block produces a pulse-width modulated output from two linked 16-bit down-counters. The master channel sets the period. It counts down from a period value and reloads when it reaches zero. At each wrap it raises a one-cycle period interrupt. The slave channel is retriggered by that interrupt. It loads a duty value and holds the PWM output active until it has counted that duty down to zero. It then stops and waits for the next interrupt.

Counting advances only on cycles where the count-clock enable is high. A start trigger and a stop trigger each act on both channels together. A trigger takes effect only when the master strobe and the slave strobe are both high in the same cycle. The period and duty values can be written at any time, but they reach the counters only when the counters reload. Both live counter values are visible on output ports at all times.

Top module: `pwm_pair_timer`

## Requirements
- R1: While reset is asserted, and after it is released, both counters, `period_irq` and `pwm_out` are 0. Reset also clears the period and duty registers to 0.
- R2: A start takes effect only when `start_master` and `start_slave` are both 1 in the same cycle. At that clock edge the master counter loads the period register, and `period_irq` is 1 for the following cycle. A lone start strobe changes nothing.
- R3: While running with the count enable high, the master counter falls by one per edge. From 0 it reloads the period register and pulses `period_irq` for one cycle. With period value P the pulse repeats every P+1 count clocks.
- R4: On an edge where `cnt_en` is 0, neither counter nor `pwm_out` changes, and `period_irq` is 0 in the next cycle.
- R5: On the edge after a cycle with `period_irq` = 1, the slave counter loads the duty value D minus one (0 when D is 0). At that same edge `pwm_out` becomes 1 if D is nonzero and 0 if D is zero, so the output turns active one count clock after the interrupt.
- R6: After a load, the slave counter falls by one per enabled edge. At the enabled edge where it is already 0, `pwm_out` goes to 0 and the slave stops until the next interrupt. The output is therefore active for D count clocks of every P+1. With D = 0 it is never active, and with D >= P+1 it is always active.
- R7: A stop takes effect only when `stop_master` and `stop_slave` are both 1 in the same cycle. Both counters and `pwm_out` then hold their values, and `period_irq` stays 0. A lone stop strobe changes nothing. A stop has priority over a start that arrives in the same cycle.
- R8: A write to the period or duty register while the counters are running does not change the period in progress. The new value is used from the next reload on.
- R9: After a stop, a start reloads both channels from the registers. `pwm_out` keeps its held level until the slave loads, one cycle after the start interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Count-clock enable; counters advance only on edges where it is high |
| start_master | input | 1 | Start strobe for the master channel |
| start_slave | input | 1 | Start strobe for the slave channel |
| stop_master | input | 1 | Stop strobe for the master channel |
| stop_slave | input | 1 | Stop strobe for the slave channel |
| period_we | input | 1 | Write enable for the period register |
| period_wdata | input | CNT_W | New period value |
| duty_we | input | 1 | Write enable for the duty register |
| duty_wdata | input | CNT_W | New duty value |
| master_count | output | CNT_W | Live master counter value |
| slave_count | output | CNT_W | Live slave counter value |
| period_irq | output | 1 | One-cycle pulse at each start and each master wrap |
| pwm_out | output | 1 | PWM output |

## Verification
Every combination of period values 0 to 4 with duty values 0 to 6 is run for three periods, and all four outputs are compared on every cycle. This sweep separates a duty of zero, duties shorter than the period, a duty equal to P+1, and duties longer than the period, as well as the degenerate period of one count clock. Separate runs cover the following cases. A write in the middle of a period shows that the running period is not disturbed. A gap in the count enable shows that the state freezes and the waveform resumes where it left off. A stop shows that the counters and output hold, and that a restart from the held level works. Lone strobes and a simultaneous start and stop show that a trigger needs both channels in the same cycle, and that stop has priority.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  // Pair-wide command decoded from the start/stop strobes.
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2
  } pair_cmd_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_master_chan.sv
module pwm_master_chan
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  pair_cmd_e        cmd_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    irq_d = 1'b0;
    case (cmd_i)
      CMD_STOP: begin
        run_d = 1'b0;
      end
      CMD_START: begin
        run_d = 1'b1;
        cnt_d = per_i;
        irq_d = 1'b1;
      end
      default: begin
        if (run_q && cnt_en_i) begin
          if (at_zero) begin
            cnt_d = per_i;
            irq_d = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_i == CMD_START) |=> (irq_q && cnt_q == $past(per_i)));

  assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && cnt_en_i && cmd_i == CMD_NONE && cnt_q == '0) |=> (irq_q && cnt_q == $past(per_i)));

  assert_idle_freeze_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cnt_en_i && cmd_i != CMD_START) |=> ($stable(cnt_q) && !irq_q));

  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_i == CMD_STOP) |=> ($stable(cnt_q) && !irq_q));

endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  pair_cmd_e        cmd_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             pwm_q, pwm_d;
  logic             duty_nz;

  assign duty_nz = (duty_i != '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    pwm_d = pwm_q;
    if (cmd_i == CMD_STOP) begin
      run_d = 1'b0;
    end else if (load_i) begin
      pwm_d = duty_nz;
      run_d = duty_nz;
      cnt_d = duty_nz ? (duty_i - ONE) : '0;
    end else if (run_q && cnt_en_i) begin
      if (cnt_q == '0) begin
        pwm_d = 1'b0;
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;

  assert_load_level_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && cmd_i != CMD_STOP) |=> (pwm_q == ($past(duty_i) != '0)));

  assert_zero_release_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && cnt_en_i && !load_i && cmd_i != CMD_STOP && cnt_q == '0) |=> !pwm_q);

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_i == CMD_STOP) |=> ($stable(pwm_q) && $stable(cnt_q)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cnt_en_i && !load_i) |=> ($stable(pwm_q) && $stable(cnt_q)));

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             start_master,
  input  logic             start_slave,
  input  logic             stop_master,
  input  logic             stop_slave,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             duty_we,
  input  logic [CNT_W-1:0] duty_wdata,
  output logic [CNT_W-1:0] master_count,
  output logic [CNT_W-1:0] slave_count,
  output logic             period_irq,
  output logic             pwm_out
);

  localparam int NUM_REGS = 2;
  localparam int IDX_PER  = 0;
  localparam int IDX_DUTY = 1;

  logic                            rst_sn;
  pair_cmd_e                       cmd;
  logic [NUM_REGS-1:0]             reg_we;
  logic [NUM_REGS-1:0][CNT_W-1:0]  reg_wdata;
  logic [NUM_REGS-1:0][CNT_W-1:0]  reg_q;
  logic [NUM_REGS-1:0][CNT_W-1:0]  reg_d;
  logic                            irq;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  // Both strobes of a pair must coincide; stop outranks start.
  always_comb begin
    if (stop_master && stop_slave)        cmd = CMD_STOP;
    else if (start_master && start_slave) cmd = CMD_START;
    else                                  cmd = CMD_NONE;
  end

  assign reg_we[IDX_PER]     = period_we;
  assign reg_we[IDX_DUTY]    = duty_we;
  assign reg_wdata[IDX_PER]  = period_wdata;
  assign reg_wdata[IDX_DUTY] = duty_wdata;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold_reg
    always_comb begin
      reg_d[g] = reg_we[g] ? reg_wdata[g] : reg_q[g];
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) reg_q[g] <= '0;
      else         reg_q[g] <= reg_d[g];
    end
  end

  pwm_master_chan #(.CNT_W(CNT_W)) u_master (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .cnt_en_i (cnt_en),
    .cmd_i    (cmd),
    .per_i    (reg_q[IDX_PER]),
    .cnt_o    (master_count),
    .irq_o    (irq)
  );

  pwm_slave_chan #(.CNT_W(CNT_W)) u_slave (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .cnt_en_i (cnt_en),
    .cmd_i    (cmd),
    .load_i   (irq),
    .duty_i   (reg_q[IDX_DUTY]),
    .cnt_o    (slave_count),
    .pwm_o    (pwm_out)
  );

  assign period_irq = irq;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sn |=> (master_count == '0 && slave_count == '0 && !period_irq && !pwm_out));

  assert_lone_start_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    ((start_master != start_slave) && !period_irq && !(stop_master && stop_slave) && !cnt_en)
      |=> ($stable(master_count) && !period_irq));

endmodule

// File: tb/sim_pwm_pair_timer.sv
`timescale 1ns/1ps
module sim_pwm_pair_timer;
  localparam int W = 16;

  logic clk;
  logic rst_n;
  logic cnt_en, start_master, start_slave, stop_master, stop_slave;
  logic period_we, duty_we;
  logic [W-1:0] period_wdata, duty_wdata;
  logic [W-1:0] master_count, slave_count;
  logic period_irq, pwm_out;

  int vecs = 0;
  int errs = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pwm_pair_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .start_master(start_master), .start_slave(start_slave),
    .stop_master(stop_master), .stop_slave(stop_slave),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .master_count(master_count), .slave_count(slave_count),
    .period_irq(period_irq), .pwm_out(pwm_out)
  );

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int em(int p, int t); return p - (t % (p + 1)); endfunction
  function automatic int eirq(int p, int t); return (t % (p + 1)) == 0 ? 1 : 0; endfunction
  function automatic int epwm(int p, int d, int t);
    return (((t - 1) % (p + 1)) < d) ? 1 : 0;
  endfunction
  function automatic int es(int p, int d, int t);
    int k;
    k = (t - 1) % (p + 1);
    if (d == 0) return 0;
    return (k < d) ? d - 1 - k : 0;
  endfunction

  task automatic check_all(int p, int d, int t, string tag);
    chk({tag, " R3 master_count"}, int'(master_count), em(p, t));
    chk({tag, " R3 period_irq"}, int'(period_irq), eirq(p, t));
    if (t >= 1) begin
      chk({tag, " R6 pwm_out"}, int'(pwm_out), epwm(p, d, t));
      chk({tag, " R5 slave_count"}, int'(slave_count), es(p, d, t));
    end
  endtask

  task automatic quiet_inputs();
    start_master = 0; start_slave = 0; stop_master = 0; stop_slave = 0;
    period_we = 0; duty_we = 0;
  endtask

  // Stop, write both registers, start; returns at the t=0 sample point.
  task automatic cfg_and_start(int p, int d);
    @(negedge clk);
    stop_master = 1; stop_slave = 1;
    period_we = 1; period_wdata = W'(p);
    duty_we = 1; duty_wdata = W'(d);
    @(negedge clk);
    quiet_inputs();
    start_master = 1; start_slave = 1;
    @(negedge clk);
    quiet_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int sm, ss, sp, e;
    rst_n = 0; cnt_en = 1; period_wdata = '0; duty_wdata = '0;
    quiet_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset master_count", int'(master_count), 0);
    chk("R1 reset slave_count", int'(slave_count), 0);
    chk("R1 reset irq", int'(period_irq), 0);
    chk("R1 reset pwm", int'(pwm_out), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release master_count", int'(master_count), 0);
    chk("R1 after release pwm", int'(pwm_out), 0);

    // Sweep of period and duty (R3, R5, R6)
    for (int p = 0; p <= 4; p++) begin
      for (int d = 0; d <= 6; d++) begin
        cfg_and_start(p, d);
        check_all(p, d, 0, "sweep R2");
        for (int t = 1; t <= 3 * (p + 1) + 2; t++) begin
          @(negedge clk);
          check_all(p, d, t, "sweep");
        end
      end
    end

    // Mid-period register write (R8)
    cfg_and_start(5, 2);
    for (int t = 1; t <= 15; t++) begin
      @(negedge clk);
      if (t <= 5) begin
        chk("R8 old period master", int'(master_count), em(5, t));
      end else begin
        chk("R8 new period master", int'(master_count), em(2, t - 6));
        chk("R8 new period irq", int'(period_irq), eirq(2, t - 6));
      end
      if (t <= 6) chk("R8 old duty pwm", int'(pwm_out), epwm(5, 2, t));
      else        chk("R8 new duty pwm", int'(pwm_out), epwm(2, 4, t - 6));
      if (t == 2) begin
        period_we = 1; period_wdata = W'(2);
        duty_we = 1; duty_wdata = W'(4);
      end
      if (t == 3) quiet_inputs();
    end

    // Count-enable gap (R4)
    cfg_and_start(4, 2);
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      e = (c <= 2) ? c : ((c >= 7) ? c - 4 : 2);
      chk("R4 gap master", int'(master_count), em(4, e));
      chk("R4 gap irq", int'(period_irq), (c >= 3 && c <= 6) ? 0 : eirq(4, e));
      chk("R4 gap pwm", int'(pwm_out), epwm(4, 2, e));
      chk("R4 gap slave", int'(slave_count), es(4, 2, e));
      if (c == 2) cnt_en = 0;
      if (c == 6) cnt_en = 1;
    end

    // Stop holds, lone starts ignored, restart from held level (R7, R2, R9)
    cfg_and_start(6, 3);
    for (int t = 1; t <= 10; t++) begin
      @(negedge clk);
      check_all(6, 3, t, "pre-stop");
    end
    sm = int'(master_count); ss = int'(slave_count); sp = int'(pwm_out);
    stop_master = 1; stop_slave = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      quiet_inputs();
      chk("R7 stop master hold", int'(master_count), sm);
      chk("R7 stop slave hold", int'(slave_count), ss);
      chk("R7 stop pwm hold", int'(pwm_out), sp);
      chk("R7 stop irq low", int'(period_irq), 0);
    end
    start_master = 1;
    @(negedge clk);
    quiet_inputs();
    @(negedge clk);
    chk("R2 lone start_master irq", int'(period_irq), 0);
    chk("R2 lone start_master count", int'(master_count), sm);
    start_slave = 1;
    @(negedge clk);
    quiet_inputs();
    @(negedge clk);
    chk("R2 lone start_slave irq", int'(period_irq), 0);
    chk("R2 lone start_slave pwm", int'(pwm_out), sp);
    start_master = 1; start_slave = 1; stop_master = 1; stop_slave = 1;
    @(negedge clk);
    quiet_inputs();
    chk("R7 stop beats start irq", int'(period_irq), 0);
    chk("R7 stop beats start count", int'(master_count), sm);
    start_master = 1; start_slave = 1;
    @(negedge clk);
    quiet_inputs();
    chk("R9 restart master reload", int'(master_count), 6);
    chk("R9 restart irq", int'(period_irq), 1);
    chk("R9 restart pwm held", int'(pwm_out), sp);
    for (int t = 1; t <= 8; t++) begin
      @(negedge clk);
      check_all(6, 3, t, "R9 restart");
    end

    // Lone stop strobe ignored while running (R7)
    cfg_and_start(3, 2);
    for (int t = 1; t <= 12; t++) begin
      @(negedge clk);
      check_all(3, 2, t, "R7 lone stop");
      if (t == 4) stop_master = 1;
      if (t == 5) begin stop_master = 0; stop_slave = 1; end
      if (t == 6) stop_slave = 0;
    end

    // Reset mid-run clears registers too (R1)
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 async clear master", int'(master_count), 0);
    chk("R1 async clear pwm", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    start_master = 1; start_slave = 1;
    @(negedge clk);
    quiet_inputs();
    check_all(0, 0, 0, "R1 cleared regs");
    for (int t = 1; t <= 3; t++) begin
      @(negedge clk);
      check_all(0, 0, t, "R1 cleared regs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule